// File: doc/BRIEF.md
# Dual-Output Multi-Mode PWM Generator

This block makes pulse-width-modulated waveforms on two outputs, `pwm_a` and `pwm_b`. One free-running counter serves both outputs. A 2-bit mode input picks how the counter and the four byte-wide compare registers are used:

- off;
- a single output whose period and duty are both 16-bit values;
- a twin 8-bit mode in which the second output has a programmable rising and falling edge;
- a twin mode with a fixed 16-bit period.

Software writes the four bytes through a small write port. The writes go into shadow copies. The active copies pick them up only at counter rollover or at a mode change, so a period is never cut short. A 2-bit `pin_en` output tells the pin multiplexer which pins the block currently drives. A lower period value gives coarser duty steps and a faster waveform. For example, a period of 4096 at 16 MHz gives about 3.9 kHz, and a period of 65536 gives about 244 Hz.

Top module: `pwm_dual_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pwm_a`, `pwm_b` and `pin_en` are all 0.
- R2: With mode 0, both outputs stay low and `pin_en` is 2'b00, whatever the register contents are.
- R3: In mode 1, the period is the 16-bit word W1 (the value 0 means 65536). `pwm_b` is high while the counter is below the 16-bit word W0. `pwm_a` stays low, and `pin_en` is 2'b10.
- R4: In mode 2, the counter period is the low byte of W1 (the value 0 means 256), and the counter never reaches 256. `pwm_a` is high while the counter is below the low byte of W0.
- R5: In mode 2, `pwm_b` is high while the counter is at or above the high byte of W1 and below the high byte of W0. When the high byte of W0 is not above the high byte of W1, `pwm_b` stays low for the whole period. When the high byte of W1 is 0, both outputs start high together at counter 0.
- R6: In mode 3, the period is 65536 whatever the registers hold. `pwm_a` is high while the counter is below W0, and `pwm_b` is high while it is below W1. At counter 0, every output with a nonzero compare word goes high.
- R7: A compare value of 0 keeps its output low for the whole period. A compare value at or above the period keeps it high for the whole period.
- R8: A write with `wr_en` high stores `wr_data` in the byte selected by `wr_addr`: 0 is the W0 low byte, 1 the W0 high byte, 2 the W1 low byte and 3 the W1 high byte. The stored value takes effect only from the next counter rollover. The active values change only in a cycle in which the counter is 0.
- R9: Each output is registered. The level for counter state k appears one clock after the counter holds k. When `mode` differs from the running mode, the next clock resets the counter to 0, drives both outputs low and loads the stored bytes. After that the counter steps by one and wraps at period minus one.
- R10: `pin_en` bit 0 marks `pwm_a` as driven and bit 1 marks `pwm_b` as driven. Its values are 2'b00 in mode 0, 2'b10 in mode 1 and 2'b11 in modes 2 and 3. It follows a mode change on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Operating mode, 0 to 3 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Byte select for a write |
| wr_data | input | 8 | Byte to store |
| pwm_a | output | 1 | First PWM output |
| pwm_b | output | 1 | Second PWM output |
| pin_en | output | 2 | Pins currently driven (bit 0 `pwm_a`, bit 1 `pwm_b`) |

## Verification
A mode change lands on the next rising edge, where the outputs read 0. The level for counter state k appears on the edge k+1 after that. A write lands one edge after its strobe, but it changes the waveform only from the first period that starts after it. The bench drives and samples on falling edges and counts them from the edge that sees the mode change. This lets every sample be matched to a known counter state. The shadow and mode-change cases are timed so that a write made inside a period is checked against the old compare value for the rest of that period and against the new value in the following period.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;

    localparam int CNT_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 4;
    localparam int ADDR_W    = $clog2(NUM_BYTES);
    localparam int PER_W     = CNT_W + 1;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PER_W-1:0] per_t;

    typedef enum logic [1:0] {
        PM_OFF    = 2'd0,
        PM_SINGLE = 2'd1,
        PM_TWIN8  = 2'd2,
        PM_TWIN16 = 2'd3
    } pwm_mode_e;

    // w0 occupies the low half: byte lanes 0/1 form w0, lanes 2/3 form w1
    typedef struct packed {
        cnt_t w1;
        cnt_t w0;
    } pwm_cfg_t;

    typedef struct packed {
        logic b;
        logic a;
    } pwm_pair_t;

    // Number of counter states in one period for a given mode
    function automatic per_t period_of(pwm_mode_e m, pwm_cfg_t c);
        per_t p;
        case (m)
            PM_SINGLE: p = (c.w1 == '0) ? (per_t'(1) << CNT_W) : {1'b0, c.w1};
            PM_TWIN8:  p = (c.w1[BYTE_W-1:0] == '0) ? (per_t'(1) << BYTE_W)
                                                    : per_t'(c.w1[BYTE_W-1:0]);
            PM_TWIN16: p = per_t'(1) << CNT_W;
            default:   p = per_t'(1);
        endcase
        return p;
    endfunction

    // Bit 0 marks output a as driven, bit 1 marks output b
    function automatic logic [1:0] pin_en_of(pwm_mode_e m);
        logic [1:0] e;
        case (m)
            PM_OFF:    e = 2'b00;
            PM_SINGLE: e = 2'b10;
            default:   e = 2'b11;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwm_dual_regs.sv
module pwm_dual_regs
    import pwm_dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              load,
    output pwm_cfg_t          active
);

    logic [NUM_BYTES*BYTE_W-1:0] shd_flat;

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_lane
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(gi))) begin
                q <= wr_data;
            end
        end
        assign shd_flat[gi*BYTE_W +: BYTE_W] = q;
    end

    // Active copy only moves at period boundaries
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (load) begin
            active <= pwm_cfg_t'(shd_flat);
        end
    end

endmodule

// File: rtl/pwm_dual_counter.sv
module pwm_dual_counter
    import pwm_dual_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  per_t period,
    output cnt_t cnt,
    output logic wrap
);

    per_t last;

    assign last = period - per_t'(1);
    // Idle counter reports a boundary every cycle so the active copy tracks writes
    assign wrap = !run || ({1'b0, cnt} == last);

    always_ff @(posedge clk) begin
        if (rst || restart || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + cnt_t'(1);
        end
    end

endmodule

// File: rtl/pwm_dual_cmp.sv
module pwm_dual_cmp
    import pwm_dual_pkg::*;
(
    input  pwm_mode_e mode,
    input  cnt_t      cnt,
    input  pwm_cfg_t  cfg,
    output pwm_pair_t level
);

    cnt_t              lims [2];
    logic [1:0]        below16;
    logic [BYTE_W-1:0] c8;
    logic              a8;
    logic              b_on;
    logic              b_off;

    assign lims[0] = cfg.w0;
    assign lims[1] = cfg.w1;

    for (genvar gi = 0; gi < 2; gi++) begin : g_wide
        assign below16[gi] = cnt < lims[gi];
    end

    assign c8    = cnt[BYTE_W-1:0];
    assign a8    = c8 < cfg.w0[BYTE_W-1:0];
    assign b_on  = c8 >= cfg.w1[CNT_W-1:BYTE_W];
    assign b_off = c8 < cfg.w0[CNT_W-1:BYTE_W];

    always_comb begin
        level = '0;
        case (mode)
            PM_SINGLE: level.b = below16[0];
            PM_TWIN8: begin
                level.a = a8;
                level.b = b_on && b_off;
            end
            PM_TWIN16: begin
                level.a = below16[0];
                level.b = below16[1];
            end
            default: level = '0;
        endcase
    end

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
    import pwm_dual_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic [1:0]        pin_en
);

    pwm_mode_e mode_in;
    pwm_mode_e mode_q;
    logic      mode_chg;
    pwm_cfg_t  act_cfg;
    cnt_t      cnt_q;
    logic      wrap;
    per_t      period;
    pwm_pair_t level;
    pwm_pair_t out_q;

    assign mode_in  = pwm_mode_e'(mode);
    assign mode_chg = (mode_in != mode_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= PM_OFF;
        end else begin
            mode_q <= mode_in;
        end
    end

    pwm_dual_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (wrap || mode_chg),
        .active  (act_cfg)
    );

    assign period = period_of(mode_q, act_cfg);

    pwm_dual_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (mode_q != PM_OFF),
        .restart (mode_chg),
        .period  (period),
        .cnt     (cnt_q),
        .wrap    (wrap)
    );

    pwm_dual_cmp u_cmp (
        .mode  (mode_q),
        .cnt   (cnt_q),
        .cfg   (act_cfg),
        .level (level)
    );

    always_ff @(posedge clk) begin
        if (rst || mode_chg) begin
            out_q <= '0;
        end else begin
            out_q <= level;
        end
    end

    assign pwm_a  = out_q.a;
    assign pwm_b  = out_q.b;
    assign pin_en = pin_en_of(mode_q);

endmodule

// File: rtl/pwm_dual_gen_chk.sv
module pwm_dual_gen_chk
    import pwm_dual_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic [1:0] mode_q,
    input cnt_t       cnt,
    input pwm_cfg_t   act_cfg,
    input logic       pwm_a,
    input logic       pwm_b,
    input logic [1:0] pin_en
);

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (pin_en == 2'b00) |-> (!pwm_a && !pwm_b));

    p_single_a_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd1) |-> !pwm_a);

    p_twin8_range_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'd2) |-> (cnt < 16'd256));

    p_load_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_cfg) |-> (cnt == 16'd0));

    p_change_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> (!pwm_a && !pwm_b && cnt == 16'd0));

    p_cnt_step_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == mode_q && mode_q != 2'd0) |=>
        (cnt == 16'd0 || cnt == $past(cnt) + 16'd1));

    p_en_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (mode != mode_q) |=> ((pin_en != 2'b00) == ($past(mode) != 2'b00)));

endmodule

bind pwm_dual_gen pwm_dual_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .mode_q  (mode_q),
    .cnt     (cnt_q),
    .act_cfg (act_cfg),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .pin_en  (pin_en)
);

// File: tb/pwm_dual_gen_tb_top.sv
module pwm_dual_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'd0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_a;
    logic       pwm_b;
    logic [1:0] pin_en;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    pwm_dual_gen dut_i (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_a   (pwm_a),
        .pwm_b   (pwm_b),
        .pin_en  (pin_en)
    );

    initial forever #4 clk = ~clk;

    typedef struct packed {
        logic [1:0]  mode;
        logic [15:0] r0;
        logic [15:0] r1;
        logic [16:0] per;
        logic [16:0] hia;
        logic [16:0] hib;
        logic        r7;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 16'h0003, 16'h000A, 17'd10,    17'd0,    17'd3,     1'b0}, // R3
        '{2'd1, 16'h0000, 16'h0008, 17'd8,     17'd0,    17'd0,     1'b1}, // R7 zero
        '{2'd1, 16'h0014, 16'h0008, 17'd8,     17'd0,    17'd8,     1'b1}, // R7 above
        '{2'd2, 16'h0704, 16'h020C, 17'd12,    17'd4,    17'd5,     1'b0}, // R4 R5
        '{2'd2, 16'h0500, 16'h0064, 17'd100,   17'd0,    17'd5,     1'b0}, // R5 percent
        '{2'd2, 16'h0302, 16'h0510, 17'd16,    17'd2,    17'd0,     1'b0}, // R5 empty window
        '{2'd2, 16'hFFFF, 16'h0008, 17'd8,     17'd8,    17'd8,     1'b1}, // R7 full
        '{2'd2, 16'h0604, 16'h000A, 17'd10,    17'd4,    17'd6,     1'b0}, // R5 joint start
        '{2'd2, 16'h4080, 16'h1000, 17'd256,   17'd128,  17'd48,    1'b0}, // R4 zero period byte
        '{2'd3, 16'h1000, 16'hFFFF, 17'd65536, 17'd4096, 17'd65535, 1'b0}  // R6
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected {b, a} for counter state k, taken from the requirements
    function automatic logic [1:0] model(input int m, input int k, input int r0, input int r1);
        logic a;
        logic b;
        a = 1'b0;
        b = 1'b0;
        case (m)
            1: b = (k < r0);
            2: begin
                a = (k < (r0 & 255));
                b = (k >= (r1 >> 8)) && (k < (r0 >> 8));
            end
            3: begin
                a = (k < r0);
                b = (k < r1);
            end
            default: ;
        endcase
        return {b, a};
    endfunction

    function automatic string tag_of(input int m, input bit second, input bit r7);
        if (r7) return "R7";
        if (m == 1) return "R3";
        if (m == 2) return second ? "R5" : "R4";
        return "R6";
    endfunction

    task automatic wr(input logic [1:0] addr, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = addr;
        wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_words(input logic [15:0] r0, input logic [15:0] r1);
        wr(2'd0, r0[7:0]);
        wr(2'd1, r0[15:8]);
        wr(2'd2, r1[7:0]);
        wr(2'd3, r1[15:8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int hia;
        int hib;
        int mism;
        int acc;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!pwm_a && !pwm_b && pin_en == 2'b00, "R1", {pin_en, pwm_b, pwm_a}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!pwm_a && !pwm_b && pin_en == 2'b00, "R1", {pin_en, pwm_b, pwm_a}, 0);

        // R2: mode 0 with loaded registers stays quiet
        load_words(16'h0005, 16'h000A);
        acc = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            acc += int'(pwm_a) + int'(pwm_b) + int'(pin_en != 2'b00);
        end
        check(acc == 0, "R2", acc, 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int m;
            int per;
            int r0;
            int r1;
            m   = int'(VECS[v].mode);
            per = int'(VECS[v].per);
            r0  = int'(VECS[v].r0);
            r1  = int'(VECS[v].r1);
            load_words(VECS[v].r0, VECS[v].r1);
            @(negedge clk);
            mode = VECS[v].mode;
            @(negedge clk);
            check(!pwm_a && !pwm_b, "R9", {pwm_b, pwm_a}, 0);
            hia = 0;
            hib = 0;
            mism = 0;
            for (int k = 0; k <= per; k++) begin
                @(negedge clk);
                if (k == 0) begin
                    check(pin_en == ((m == 1) ? 2'b10 : 2'b11), "R10",
                          int'(pin_en), (m == 1) ? 2 : 3);
                end
                if ({pwm_b, pwm_a} != model(m, k % per, r0, r1)) mism++;
                if (k < per) begin
                    hia += int'(pwm_a);
                    hib += int'(pwm_b);
                end
            end
            check(hia == int'(VECS[v].hia), tag_of(m, 1'b0, VECS[v].r7), hia, int'(VECS[v].hia));
            check(hib == int'(VECS[v].hib), tag_of(m, 1'b1, VECS[v].r7), hib, int'(VECS[v].hib));
            check(mism == 0, tag_of(m, 1'b1, 1'b0), mism, 0);
            mode = 2'd0;
            @(negedge clk);
            check(!pwm_a && !pwm_b && pin_en == 2'b00, "R2", {pin_en, pwm_b, pwm_a}, 0);
        end

        // R8: a write mid-period waits for rollover
        load_words(16'h0003, 16'h000A);
        @(negedge clk);
        mode = 2'd1;
        @(negedge clk);
        for (int k = 0; k < 4; k++) @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 2'd0;
        wr_data = 8'd6;
        @(negedge clk);
        wr_en = 1'b0;
        acc = 0;
        for (int k = 5; k < 10; k++) begin
            @(negedge clk);
            acc += int'(pwm_b);
        end
        check(acc == 0, "R8", acc, 0);
        hib = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            hib += int'(pwm_b);
        end
        check(hib == 6, "R8", hib, 6);

        // R9: mode change mid-period restarts from zero
        @(negedge clk);
        @(negedge clk);
        check(pwm_b == 1'b1, "R3", int'(pwm_b), 1);
        mode = 2'd2;
        @(negedge clk);
        check(!pwm_a && !pwm_b, "R9", {pwm_b, pwm_a}, 0);
        check(pin_en == 2'b11, "R10", int'(pin_en), 3);
        @(negedge clk);
        check(pwm_a == 1'b1 && pwm_b == 1'b0, "R9", {pwm_b, pwm_a}, 1);
        mode = 2'd0;
        @(negedge clk);
        check(pin_en == 2'b00, "R10", int'(pin_en), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule